// File: doc/BRIEF.md
# Pipelined Subfield-Arithmetic AES Substitution Box

This block computes the forward AES byte substitution for one 8-bit value per clock. It holds no table. The input byte is first moved into a tower representation: a degree-two extension over the sixteen-element field. In that representation the multiplicative inverse needs only nibble multiplies, nibble squares and one nibble inverse. The result then goes through a single constant linear map. That map combines the return to the standard polynomial basis with the linear part of the AES affine step. The constant 0x63 is added last. Zero has no inverse, so it is passed through as zero, and an input of 0x00 therefore yields 0x63.

The logic is split across seven register stages so that each stage holds only a small amount of nibble arithmetic. A byte presented with its valid flag is accepted on every clock edge, with no stalls, and its result leaves exactly seven edges later together with a matching valid flag. All basis-change matrices and the subfield constant are derived at elaboration from the field definitions, so no hand-entered matrix appears in the code.

Top module: `aes_sbox_pipe`

## Requirements
- R1: For every input byte x, the output byte equals A(inv(x)) xor 0x63. Here inv is the multiplicative inverse modulo x^8+x^4+x^3+x+1 and A is the linear map b_i = a_i ^ a_(i+4) ^ a_(i+5) ^ a_(i+6) ^ a_(i+7), with indices mod 8. Examples: 0x01 gives 0x7C, 0x53 gives 0xED, 0xFF gives 0x16.
- R2: An input of 0x00 gives 0x63, because zero is mapped to zero in place of an inverse.
- R3: A byte accepted on a rising edge with in_valid high appears on out_byte, with out_valid high, after exactly seven rising edges. It is not visible earlier.
- R4: A new byte is accepted on every edge with no stall. A run of back-to-back valid inputs produces an equally long run of back-to-back valid outputs, in the same order.
- R5: out_valid is high in a cycle exactly when in_valid was high seven edges earlier. Idle input cycles give idle output cycles.
- R6: While rst_n is low, and for the seven edges after it rises, out_valid stays low. Bytes that were in flight when reset was applied never reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_byte as a byte to substitute this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Marks out_byte as a finished result |
| out_byte | output | 8 | Substituted byte, seven edges after its input |

## Verification
The hardest situation to reach from the ports is a pipeline whose seven stages all hold different bytes at once, mixed with bubbles. A fault in one stage's nibble arithmetic or in the valid alignment only shows up when neighbouring stages hold different data. The stimulus handles this by sweeping all 256 values back to back and then sending a long fixed-seed random stream in which roughly a third of the cycles are bubbles. A reset is also asserted while bytes are in flight, so that flushed data would show up as a spurious valid output. A single isolated byte is timed edge by edge to pin the latency at seven.

// File: rtl/sbox_gf_pkg.sv
// Package: tower-field arithmetic for the AES S-box.
// Nibble field GF(16) uses x^4+x+1. Byte elements are {hi,lo} = hi*y + lo
// with y^2 = y + LAMBDA. LAMBDA and both basis-change maps are derived by
// constant functions from the field definitions.
package sbox_gf_pkg;

    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int PIPE_DEPTH = 7;
    localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Multiply in GF(16) modulo x^4+x+1.
    function automatic nib_t gf4_mul(nib_t a, nib_t b);
        nib_t acc;
        nib_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[NIB_W-2:0], 1'b0} ^ (sh[NIB_W-1] ? nib_t'(4'h3) : nib_t'(4'h0));
        end
        return acc;
    endfunction

    // Square in GF(16).
    function automatic nib_t gf4_sq(nib_t a);
        return gf4_mul(a, a);
    endfunction

    // Inverse in GF(16) as a^14; zero maps to zero.
    function automatic nib_t gf4_inv(nib_t a);
        nib_t s2, s4, s8;
        s2 = gf4_sq(a);
        s4 = gf4_sq(s2);
        s8 = gf4_sq(s4);
        return gf4_mul(gf4_mul(s2, s4), s8);
    endfunction

    // Smallest constant making y^2+y+c irreducible over GF(16).
    function automatic nib_t find_lambda();
        nib_t res;
        logic done;
        res  = '0;
        done = 1'b0;
        for (int c = 1; c < 16; c++) begin
            logic has_root;
            has_root = 1'b0;
            for (int t = 0; t < 16; t++)
                if ((gf4_sq(nib_t'(t)) ^ nib_t'(t)) == nib_t'(c)) has_root = 1'b1;
            if (!has_root && !done) begin
                res  = nib_t'(c);
                done = 1'b1;
            end
        end
        return res;
    endfunction

    localparam nib_t LAMBDA = find_lambda();

    // Multiply two tower-field bytes.
    function automatic byte_t tower_mul(byte_t a, byte_t b);
        nib_t ah, al, bh, bl, hh;
        ah = a[7:4]; al = a[3:0];
        bh = b[7:4]; bl = b[3:0];
        hh = gf4_mul(ah, bh);
        return {hh ^ gf4_mul(ah, bl) ^ gf4_mul(al, bh),
                gf4_mul(hh, LAMBDA) ^ gf4_mul(al, bl)};
    endfunction

    // First tower element that is a root of the AES field polynomial.
    function automatic byte_t find_beta();
        byte_t res;
        logic done;
        res  = '0;
        done = 1'b0;
        for (int c = 2; c < 256; c++) begin
            byte_t x, x2, x4, x8, p;
            x  = byte_t'(c);
            x2 = tower_mul(x, x);
            x4 = tower_mul(x2, x2);
            x8 = tower_mul(x4, x4);
            p  = x8 ^ x4 ^ tower_mul(x2, x) ^ x ^ 8'h01;
            if (p == '0 && !done) begin
                res  = x;
                done = 1'b1;
            end
        end
        return res;
    endfunction

    // Apply a linear map given as eight packed byte columns.
    function automatic byte_t lin_map(byte_t a, logic [8*BYTE_W-1:0] cols);
        byte_t q;
        q = '0;
        for (int i = 0; i < BYTE_W; i++)
            if (a[i]) q = q ^ cols[i*BYTE_W +: BYTE_W];
        return q;
    endfunction

    // Linear part of the AES affine transform.
    function automatic byte_t affine_lin(byte_t a);
        byte_t b;
        for (int i = 0; i < BYTE_W; i++)
            b[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8];
        return b;
    endfunction

    // Columns of the entry map: column i is beta^i.
    function automatic logic [8*BYTE_W-1:0] make_enter_cols();
        logic [8*BYTE_W-1:0] cols;
        byte_t pw, beta;
        beta = find_beta();
        pw   = 8'h01;
        for (int i = 0; i < BYTE_W; i++) begin
            cols[i*BYTE_W +: BYTE_W] = pw;
            pw = tower_mul(pw, beta);
        end
        return cols;
    endfunction

    localparam logic [8*BYTE_W-1:0] ENTER_COLS = make_enter_cols();

    // Columns of the exit map: inverse basis change merged with the affine part.
    function automatic logic [8*BYTE_W-1:0] make_exit_cols();
        logic [8*BYTE_W-1:0] cols;
        cols = '0;
        for (int j = 0; j < BYTE_W; j++)
            for (int c = 0; c < 256; c++)
                if (lin_map(byte_t'(c), ENTER_COLS) == (byte_t'(1) << j))
                    cols[j*BYTE_W +: BYTE_W] = affine_lin(byte_t'(c));
        return cols;
    endfunction

    localparam logic [8*BYTE_W-1:0] EXIT_COLS = make_exit_cols();

endpackage

// File: rtl/sbox_enter_stage.sv
// Stages 1-2: capture the input byte, then move it into the tower basis.
// Assumes the caller tracks validity; data registers clear on reset.
module sbox_enter_stage
    import sbox_gf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t din,
    output nib_t  hi_q,
    output nib_t  lo_q
);
    byte_t cap_q;
    byte_t map_q;

    // Stage 1: register the raw byte.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= din;
    end

    // Stage 2: register the byte expressed in the tower basis.
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= lin_map(cap_q, ENTER_COLS);
    end

    assign hi_q = map_q[7:4];
    assign lo_q = map_q[3:0];
endmodule

// File: rtl/sbox_norm_stage.sv
// Stages 3-4: form the norm h^2*LAMBDA + h*l + l^2 of the tower element.
// The three terms are registered apart before they are summed, to keep depth low.
module sbox_norm_stage
    import sbox_gf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  nib_t hi,
    input  nib_t lo,
    output nib_t hi_q,
    output nib_t sum_q,
    output nib_t norm_q
);
    nib_t h3, s3, ta3, tb3, tc3;

    // Stage 3: register the three norm terms and the conjugate sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h3 <= '0; s3 <= '0; ta3 <= '0; tb3 <= '0; tc3 <= '0;
        end else begin
            h3  <= hi;
            s3  <= hi ^ lo;
            ta3 <= gf4_mul(gf4_sq(hi), LAMBDA);
            tb3 <= gf4_mul(hi, lo);
            tc3 <= gf4_sq(lo);
        end
    end

    // Stage 4: register the summed norm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0; sum_q <= '0; norm_q <= '0;
        end else begin
            hi_q   <= h3;
            sum_q  <= s3;
            norm_q <= ta3 ^ tb3 ^ tc3;
        end
    end
endmodule

// File: rtl/sbox_invmul_stage.sv
// Stages 5-6: invert the norm in GF(16), then scale the conjugate by it.
// A zero norm inverts to zero, so a zero byte leaves as zero.
module sbox_invmul_stage
    import sbox_gf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  nib_t  hi,
    input  nib_t  sum,
    input  nib_t  norm,
    output byte_t inv_q
);
    nib_t h5, s5, d5;

    // Stage 5: register the nibble inverse of the norm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h5 <= '0; s5 <= '0; d5 <= '0;
        end else begin
            h5 <= hi;
            s5 <= sum;
            d5 <= gf4_inv(norm);
        end
    end

    // Stage 6: register the tower-basis inverse {h*d, (h^l)*d}.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= '0;
        else        inv_q <= {gf4_mul(h5, d5), gf4_mul(s5, d5)};
    end
endmodule

// File: rtl/sbox_exit_stage.sv
// Stage 7: one merged linear map (basis return plus affine part) and the constant.
module sbox_exit_stage
    import sbox_gf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t inv,
    output byte_t dout
);
    // Stage 7: register the finished substitution.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= lin_map(inv, EXIT_COLS) ^ AFFINE_C;
    end
endmodule

// File: rtl/aes_sbox_pipe.sv
// Top: seven-stage forward AES S-box using tower-field inversion.
// Accepts one byte per edge; valid travels in a shift register of PIPE_DEPTH.
module aes_sbox_pipe
    import sbox_gf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    nib_t  e_hi, e_lo;
    nib_t  n_hi, n_sum, n_norm;
    byte_t inv_b;
    logic [PIPE_DEPTH-1:0] vld_sr;

    sbox_enter_stage u_enter (
        .clk(clk), .rst_n(rst_n), .din(in_byte), .hi_q(e_hi), .lo_q(e_lo)
    );

    sbox_norm_stage u_norm (
        .clk(clk), .rst_n(rst_n), .hi(e_hi), .lo(e_lo),
        .hi_q(n_hi), .sum_q(n_sum), .norm_q(n_norm)
    );

    sbox_invmul_stage u_inv (
        .clk(clk), .rst_n(rst_n), .hi(n_hi), .sum(n_sum), .norm(n_norm),
        .inv_q(inv_b)
    );

    sbox_exit_stage u_exit (
        .clk(clk), .rst_n(rst_n), .inv(inv_b), .dout(out_byte)
    );

    // Move the valid flag alongside the data, one stage per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[PIPE_DEPTH-2:0], in_valid};
    end

    assign out_valid = vld_sr[PIPE_DEPTH-1];
endmodule

// File: rtl/sbox_pipe_checker.sv
// Checker for aes_sbox_pipe: tracks input history in its own shift
// registers and relates it to the outputs seven edges later.
module sbox_pipe_checker
    import sbox_gf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [7:0] out_byte
);
    localparam int AGE_W = $clog2(PIPE_DEPTH + 1);

    logic [PIPE_DEPTH-1:0] v_hist, z_hist, one_hist;
    logic [AGE_W-1:0]      age;

    // Record valid, zero-input and one-input history; count edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_hist <= '0; z_hist <= '0; one_hist <= '0; age <= '0;
        end else begin
            v_hist   <= {v_hist[PIPE_DEPTH-2:0], in_valid};
            z_hist   <= {z_hist[PIPE_DEPTH-2:0], in_byte == 8'h00};
            one_hist <= {one_hist[PIPE_DEPTH-2:0], in_byte == 8'h01};
            if (age != AGE_W'(PIPE_DEPTH)) age <= age + 1'b1;
        end
    end

    assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == AGE_W'(PIPE_DEPTH)) |-> (out_valid == v_hist[PIPE_DEPTH-1]));

    assert_zero_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_hist[PIPE_DEPTH-1] && z_hist[PIPE_DEPTH-1]) |-> (out_byte == 8'h63));

    assert_one_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (v_hist[PIPE_DEPTH-1] && one_hist[PIPE_DEPTH-1]) |-> (out_byte == 8'h7C));

    assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age != AGE_W'(PIPE_DEPTH)) |-> !out_valid);

    assert_known_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_byte));
endmodule

bind aes_sbox_pipe sbox_pipe_checker u_chk (.*);

// File: tb/aes_sbox_pipe_test.sv
module aes_sbox_pipe_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;
    logic [7:0] ref_tab [256];

    logic       exp_v [7];
    logic [7:0] exp_d [7];

    always #2 clk = ~clk;

    aes_sbox_pipe uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_sbox(logic [7:0] v);
        logic [7:0] inv = 8'h00;
        logic [7:0] b;
        for (int y = 1; y < 256; y++)
            if (gmul(v, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return b ^ 8'h63;
    endfunction

    task automatic check(logic ok, string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // Bench model of the latency: expected valid/data seven edges later.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) begin exp_v[i] <= 1'b0; exp_d[i] <= 8'h00; end
        end else begin
            exp_v[0] <= in_valid;
            exp_d[0] <= ref_tab[in_byte];
            for (int i = 1; i < 7; i++) begin exp_v[i] <= exp_v[i-1]; exp_d[i] <= exp_d[i-1]; end
        end
    end

    // Compare outputs against the model mid-cycle (R1, R4, R5).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(out_valid == exp_v[6], "R5 valid timing", {7'd0, out_valid}, {7'd0, exp_v[6]});
            if (exp_v[6] && out_valid)
                check(out_byte == exp_d[6], "R1 R4 data", out_byte, exp_d[6]);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic v, logic [7:0] d);
        in_valid = v;
        in_byte  = d;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_tab[i] = ref_sbox(8'(i));
        cyc(3);
        check(out_valid == 1'b0, "R6 reset state", {7'd0, out_valid}, 8'h00);
        rst_n = 1'b1;

        // Directed known values (R1, R2).
        check(ref_tab[8'h00] == 8'h63, "R2 reference", ref_tab[8'h00], 8'h63);
        send(1'b1, 8'h00);
        send(1'b1, 8'h01);
        send(1'b1, 8'h53);
        send(1'b1, 8'hFF);
        send(1'b0, 8'h00);
        cyc(2);
        check(out_valid && out_byte == 8'h63, "R2 zero input", out_byte, 8'h63);
        cyc(1);
        check(out_valid && out_byte == 8'h7C, "R1 input 01", out_byte, 8'h7C);
        cyc(1);
        check(out_valid && out_byte == 8'hED, "R1 input 53", out_byte, 8'hED);
        cyc(1);
        check(out_valid && out_byte == 8'h16, "R1 input FF", out_byte, 8'h16);
        cyc(4);

        // Isolated byte: timed edge by edge (R3).
        send(1'b1, 8'hA5);
        in_valid = 1'b0;
        for (int k = 1; k < 7; k++) begin
            check(!out_valid, "R3 early output", {7'd0, out_valid}, 8'h00);
            cyc(1);
        end
        check(out_valid && out_byte == ref_tab[8'hA5], "R3 seven-edge latency", out_byte, ref_tab[8'hA5]);
        cyc(3);

        // Full sweep, back to back (R1, R4).
        for (int i = 0; i < 256; i++) send(1'b1, 8'(i));
        send(1'b0, 8'h00);
        cyc(8);

        // Random stream with bubbles, fixed seed.
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < 2000; i++)
            send(($urandom % 3) != 0, 8'($urandom));
        send(1'b0, 8'h00);
        cyc(8);

        // Reset with bytes in flight (R6).
        for (int i = 0; i < 4; i++) send(1'b1, 8'(8'h30 + i));
        in_valid = 1'b0;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            check(!out_valid, "R6 flushed after reset", {7'd0, out_valid}, 8'h00);
            cyc(1);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule